// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block takes 8-bit pixels from an image sensor's parallel port and packs them into 32-bit words in a small FIFO. A DMA engine outside the block drains that FIFO. The block runs entirely on one functional clock. It watches the sensor's pixel clock as an ordinary input and samples the data, the line-valid sync and the frame-valid sync on the pixel-clock edge that has been selected. The functional clock therefore has to run at least four times faster than the pixel clock, so that each pixel-clock phase lasts two or more functional cycles. Pixels count only while both syncs are active. Blanking samples are thrown away, and the format of the pixel data is never interpreted.

A pixel can only be accepted once the block is armed. In wait-for-frame mode the block arms on the first inactive-to-active transition of the frame sync. In immediate mode it arms as soon as it is enabled. The FIFO raises a level request while its fill reaches a programmable threshold. At every frame end it also pulses a second request, after pushing any partial word, so that the remainder can be collected. The FIFO output is a valid/ready stream. The consumer may hold ready low for as long as it likes and the head word stays put. The pixel input cannot be stalled, so a full FIFO loses data and latches an error. A separate divider produces the sensor's reference clock from the functional clock.

Top module: `pcam_capture_top`

## Requirements
- R1: A pixel is accepted only at a selected pixel-clock edge where both line sync and frame sync are active. Samples taken during blanking never reach the FIFO.
- R2: `hs_inv`=1 makes line sync active low and `vs_inv`=1 makes frame sync active low. With 0 the sync is active high. The two bits are independent.
- R3: `pclk_fall`=0 samples on rising pixel-clock edges and `pclk_fall`=1 samples on falling edges. Data present only at the other edge is never taken.
- R4: The pixel is `pix_data[11:4]`, and bits [3:0] are ignored. Four accepted pixels form one word, little-endian: the first pixel goes in bits [7:0] and the fourth in bits [31:24].
- R5: With `wait_frame`=1, pixels arriving before the first frame-sync inactive-to-active transition after enable are dropped, and no end-of-frame request is raised for that partial frame. With `wait_frame`=0, capture starts at once. `enable`=0 disarms the block and clears the packer.
- R6: At a frame-sync active-to-inactive transition while armed, a partial word is zero-padded and pushed. `eof_req` then pulses high for exactly one cycle, with that word already visible at the output.
- R7: `thresh_req` is high exactly while the FIFO level is at least `thresh`, and `thresh`=0 holds it low.
- R8: `out_data` is the oldest word, in push order, while `out_valid` is high. A word leaves only on a cycle with `out_valid` and `out_ready` both high. While it waits, `out_data` holds.
- R9: A word that finds the FIFO full is lost, and `overflow` goes high and stays high. Further pixels are dropped until the next frame start, and `enable`=0 clears the flag.
- R10: With `clk_div`=N≥2, `sensor_clk` has period N cycles and is high for floor(N/2) of them. With N<2 it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Capture enable; low disarms, clears packer and error |
| wait_frame | input | 1 | 1: arm on frame start; 0: arm at once |
| hs_inv | input | 1 | Line sync active low when 1 |
| vs_inv | input | 1 | Frame sync active low when 1 |
| pclk_fall | input | 1 | Sample on falling pixel-clock edge when 1 |
| thresh | input | LVL_W | FIFO level request threshold, 0 disables |
| clk_div | input | DIV_W | Sensor clock divide value |
| pix_clk | input | 1 | Sensor pixel clock, sampled |
| hsync | input | 1 | Line sync |
| vsync | input | 1 | Frame sync |
| pix_data | input | 12 | Parallel data, pixel on [11:4] |
| out_valid | output | 1 | FIFO head word available |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | 32 | FIFO head word |
| thresh_req | output | 1 | Level request at or above threshold |
| eof_req | output | 1 | One-cycle end-of-frame drain request |
| overflow | output | 1 | Sticky overflow error |
| sensor_clk | output | 1 | Divided sensor reference clock |

## Verification
The hardest situation to reach from the ports is an overflow that is followed by a clean recovery. The FIFO has to fill in the middle of a frame and the words after that have to be lost. Then, in the next frame, the drop state has to clear while the error flag stays set. The stimulus gets there by holding ready low through a 40-pixel frame into an 8-word FIFO, draining, and sending a short second frame. Enabling in wait-for-frame mode while the frame sync is already active is a second case that needs care: the sync is held active through the enable, so the later frame end must produce neither data nor a request.

// File: rtl/pcam_pkg.sv
package pcam_pkg;
  localparam int PIX_W       = 8;
  localparam int PIX_PER_WRD = 4;
  localparam int WORD_W      = PIX_W * PIX_PER_WRD;
  localparam int PORT_W      = 12;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic hs_inv;
    logic vs_inv;
    logic pclk_fall;
    logic wait_frame;
  } cap_cfg_t;
endpackage

// File: rtl/pcam_sync_capture.sv
module pcam_sync_capture
  import pcam_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  cap_cfg_t cfg,
  input  logic     pix_clk,
  input  logic     hsync,
  input  logic     vsync,
  input  pix_t     pix,
  input  logic     fifo_full,
  output logic     push,
  output word_t    push_data,
  output logic     eof_req,
  output logic     overflow
);
  localparam int CNT_W = $clog2(PIX_PER_WRD);

  logic             pclk_q, vs_prev, armed, dropping;
  logic [CNT_W-1:0] byte_cnt, cnt_base;
  word_t            word_q, merged;
  logic sample_evt, hs_act, vs_act, frame_start, frame_end;
  logic arm_eff, drop_eff, accept, push_full, push_tail, push_req, ovf_now;

  always_comb begin
    sample_evt  = (pix_clk ^ pclk_q) & (pix_clk ^ cfg.pclk_fall);
    hs_act      = hsync ^ cfg.hs_inv;
    vs_act      = vsync ^ cfg.vs_inv;
    frame_start = sample_evt & vs_act & ~vs_prev;
    frame_end   = sample_evt & ~vs_act & vs_prev;
    arm_eff     = enable & (armed | ~cfg.wait_frame | frame_start);
    drop_eff    = dropping & ~frame_start;
    accept      = sample_evt & arm_eff & hs_act & vs_act & ~drop_eff;
    cnt_base    = frame_start ? '0 : byte_cnt;
    merged      = frame_start ? '0 : word_q;
    if (accept) merged[PIX_W*cnt_base +: PIX_W] = pix;
    push_full   = accept & (cnt_base == CNT_W'(PIX_PER_WRD-1));
    push_tail   = frame_end & arm_eff & (byte_cnt != '0) & ~dropping;
    push_req    = push_full | push_tail;
    ovf_now     = push_req & fifo_full;
    push        = push_req & ~fifo_full;
    push_data   = merged;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pclk_q   <= 1'b0;
      vs_prev  <= 1'b1;
      armed    <= 1'b0;
      dropping <= 1'b0;
      overflow <= 1'b0;
      eof_req  <= 1'b0;
      byte_cnt <= '0;
      word_q   <= '0;
    end else begin
      pclk_q  <= pix_clk;
      if (sample_evt) vs_prev <= vs_act;
      armed   <= arm_eff;
      eof_req <= frame_end & arm_eff;
      if (!enable) begin
        byte_cnt <= '0;
        word_q   <= '0;
        dropping <= 1'b0;
        overflow <= 1'b0;
      end else begin
        if (push_req || frame_end || frame_start) begin
          byte_cnt <= (accept && !push_req) ? cnt_base + 1'b1 : '0;
          word_q   <= (accept && !push_req) ? merged : '0;
        end else if (accept) begin
          byte_cnt <= cnt_base + 1'b1;
          word_q   <= merged;
        end
        if (ovf_now) begin
          dropping <= 1'b1;
          overflow <= 1'b1;
        end else if (frame_start) begin
          dropping <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pcam_word_fifo.sv
module pcam_word_fifo #(
  parameter  int W     = 32,
  parameter  int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          not_empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (level == LW'(DEPTH));
  assign not_empty = (level != '0);
  assign dout      = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/pcam_clk_div.sv
module pcam_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             sclk
);
  logic [DIV_W-1:0] cnt;
  logic             active;

  assign active = (div >= DIV_W'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      if (!active || cnt >= div - 1'b1) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
      sclk <= active && (cnt < (div >> 1));
    end
  end
endmodule

// File: rtl/pcam_capture_top.sv
module pcam_capture_top
  import pcam_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int DIV_W = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wait_frame,
  input  logic              hs_inv,
  input  logic              vs_inv,
  input  logic              pclk_fall,
  input  logic [LVL_W-1:0]  thresh,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              pix_clk,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [PORT_W-1:0] pix_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              thresh_req,
  output logic              eof_req,
  output logic              overflow,
  output logic              sensor_clk
);
  cap_cfg_t         cfg;
  logic             push, fifo_full;
  word_t            push_data;
  logic [LVL_W-1:0] fifo_level;
  logic             unused_low;

  assign cfg        = '{hs_inv: hs_inv, vs_inv: vs_inv,
                        pclk_fall: pclk_fall, wait_frame: wait_frame};
  assign unused_low = ^pix_data[PORT_W-PIX_W-1:0];

  pcam_sync_capture u_cap (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg(cfg),
    .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync),
    .pix(pix_data[PORT_W-1 -: PIX_W]), .fifo_full(fifo_full),
    .push(push), .push_data(push_data),
    .eof_req(eof_req), .overflow(overflow)
  );

  pcam_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_data),
    .pop(out_valid & out_ready), .dout(out_data), .full(fifo_full),
    .not_empty(out_valid), .level(fifo_level)
  );

  pcam_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div(clk_div), .sclk(sensor_clk)
  );

  assign thresh_req = (thresh != '0) && (fifo_level >= thresh);
endmodule

// File: rtl/pcam_capture_chk.sv
module pcam_capture_chk #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_data,
  input logic             thresh_req,
  input logic             eof_req,
  input logic             overflow,
  input logic [DIV_W-1:0] clk_div,
  input logic             sensor_clk,
  input logic [LVL_W-1:0] level
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  p_thresh_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_req |-> out_valid);

  p_eof_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eof_req |=> !eof_req);

  p_eof_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !eof_req);

  p_no_overflow_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && enable |=> overflow);

  p_overflow_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !overflow);

  p_sclk_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_div < DIV_W'(2) |=> !sensor_clk);
endmodule

bind pcam_capture_top pcam_capture_chk #(.DEPTH(DEPTH), .DIV_W(DIV_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .thresh_req(thresh_req),
  .eof_req(eof_req), .overflow(overflow), .clk_div(clk_div),
  .sensor_clk(sensor_clk), .level(fifo_level)
);

// File: tb/tb_pcam_capture_top.sv
module tb_pcam_capture_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int LVL_W      = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, wait_frame = 1'b1;
  logic hs_inv = 1'b0, vs_inv = 1'b0, pclk_fall = 1'b0;
  logic [LVL_W-1:0] thresh = '0;
  logic [7:0] clk_div = '0;
  logic pix_clk = 1'b0, hsync = 1'b0, vsync = 1'b0, out_ready = 1'b0;
  logic [11:0] pix_data = '0;
  logic out_valid, thresh_req, eof_req, overflow, sensor_clk;
  logic [31:0] out_data;

  int n_chk = 0, n_bad = 0, eof_cnt = 0;

  // {hs_inv, vs_inv, pclk_fall, pixel count}
  localparam logic [8:0] VEC [6] = '{
    {3'b000, 6'd4}, {3'b100, 6'd5}, {3'b011, 6'd7},
    {3'b111, 6'd8}, {3'b001, 6'd1}, {3'b110, 6'd10}
  };

  pcam_capture_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wait_frame(wait_frame),
    .hs_inv(hs_inv), .vs_inv(vs_inv), .pclk_fall(pclk_fall),
    .thresh(thresh), .clk_div(clk_div), .pix_clk(pix_clk),
    .hsync(hsync), .vsync(vsync), .pix_data(pix_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .thresh_req(thresh_req), .eof_req(eof_req), .overflow(overflow),
    .sensor_clk(sensor_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n && eof_req) eof_cnt <= eof_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One pixel: data at the idle level, active edge, then junk at the idle edge.
  task automatic pix(input bit hs_a, input bit vs_a, input logic [7:0] b);
    @(negedge clk);
    hsync = hs_a ^ hs_inv; vsync = vs_a ^ vs_inv;
    pix_data = {b, 4'hA}; pix_clk = pclk_fall;
    repeat (2) @(negedge clk);
    pix_clk = ~pclk_fall;
    repeat (2) @(negedge clk);
    pix_data = {8'h55, 4'h5};
    @(negedge clk);
    pix_clk = pclk_fall;
    @(negedge clk);
  endtask

  task automatic frame(input int n, input logic [7:0] base);
    pix(1, 0, 8'hEE);
    pix(0, 0, 8'hEE);
    pix(0, 1, 8'hEE);
    for (int i = 0; i < n; i++) pix(1, 1, base + 8'(i));
    pix(0, 1, 8'hEE);
    pix(0, 0, 8'hEE);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] base, input int n, input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (4*w + k < n) r[8*k +: 8] = base + 8'(4*w + k);
    return r;
  endfunction

  task automatic drain(input logic [7:0] base, input int n, input string req);
    @(negedge clk);
    for (int w = 0; w < (n + 3) / 4; w++) begin
      chk({req, " valid"}, 32'(out_valid), 32'd1);
      chk({req, " word"}, out_data, exp_word(base, n, w));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk({req, " empty after drain"}, 32'(out_valid), 32'd0);
  endtask

  task automatic pop_one();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic count_high(input logic [7:0] d, input int exp, input string req);
    int hi = 0;
    clk_div = d;
    repeat (12) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sensor_clk) hi++;
    end
    chk(req, 32'(hi), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    thresh = 2;
    @(negedge clk);
    chk("reset out_valid R8", 32'(out_valid), 0);
    chk("reset overflow R9", 32'(overflow), 0);
    chk("reset eof_req R6", 32'(eof_req), 0);
    chk("reset thresh_req R7", 32'(thresh_req), 0);
    chk("reset sensor_clk R10", 32'(sensor_clk), 0);
    thresh = 0;

    // Table: polarity (R2), edge (R3), blanking (R1), packing (R4), tail (R6)
    for (int k = 0; k < 6; k++) begin
      enable = 1'b0;
      {hs_inv, vs_inv, pclk_fall} = VEC[k][8:6];
      wait_frame = 1'b1;
      pix(0, 0, 8'hEE);
      enable = 1'b1;
      e0 = eof_cnt;
      frame(int'(VEC[k][5:0]), 8'(16*k + 1));
      chk("R6 one eof pulse per frame", 32'(eof_cnt - e0), 1);
      drain(8'(16*k + 1), int'(VEC[k][5:0]), "R1 R2 R3 R4 table");
    end

    // R5: wait-for-frame mode enabled mid-frame
    enable = 1'b0; {hs_inv, vs_inv, pclk_fall} = 3'b000; wait_frame = 1'b1;
    pix(1, 1, 8'h77);
    enable = 1'b1;
    e0 = eof_cnt;
    for (int i = 0; i < 4; i++) pix(1, 1, 8'hA0 + 8'(i));
    pix(0, 0, 8'hEE);
    repeat (2) @(negedge clk);
    chk("R5 mid-frame data dropped", 32'(out_valid), 0);
    chk("R5 no eof for partial frame", 32'(eof_cnt - e0), 0);
    frame(4, 8'h80);
    chk("R5 eof after clean frame", 32'(eof_cnt - e0), 1);
    drain(8'h80, 4, "R5 clean frame");

    // R5: immediate mode mid-frame, with padded tail R6
    enable = 1'b0; wait_frame = 1'b0;
    pix(1, 1, 8'h77);
    enable = 1'b1;
    e0 = eof_cnt;
    for (int i = 0; i < 6; i++) pix(1, 1, 8'h90 + 8'(i));
    pix(0, 0, 8'hEE);
    repeat (2) @(negedge clk);
    chk("R5 immediate eof", 32'(eof_cnt - e0), 1);
    drain(8'h90, 6, "R5 R6 immediate padded");

    // R7 threshold, R8 hold
    enable = 1'b0; wait_frame = 1'b1; thresh = 2;
    pix(0, 0, 8'hEE);
    enable = 1'b1;
    frame(12, 8'hB0);
    chk("R7 level 3 thr 2", 32'(thresh_req), 1);
    chk("R8 head word", out_data, exp_word(8'hB0, 12, 0));
    repeat (3) @(negedge clk);
    chk("R8 head held without ready", out_data, exp_word(8'hB0, 12, 0));
    pop_one();
    chk("R7 level 2 thr 2", 32'(thresh_req), 1);
    chk("R8 second word", out_data, exp_word(8'hB0, 12, 1));
    pop_one();
    chk("R7 level 1 thr 2", 32'(thresh_req), 0);
    thresh = 0;
    @(negedge clk);
    chk("R7 thr 0 disables", 32'(thresh_req), 0);
    thresh = 1;
    @(negedge clk);
    chk("R7 level 1 thr 1", 32'(thresh_req), 1);
    chk("R8 third word", out_data, exp_word(8'hB0, 12, 2));
    pop_one();
    thresh = 0;

    // R9 overflow, drop, recovery at next frame start
    frame(40, 8'h00);
    chk("R9 overflow set", 32'(overflow), 1);
    drain(8'h00, 32, "R9 kept words");
    frame(4, 8'hC0);
    chk("R9 overflow sticky", 32'(overflow), 1);
    drain(8'hC0, 4, "R9 recovered frame");
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 disable clears overflow", 32'(overflow), 0);

    // R10 divider
    count_high(8'd4, 20, "R10 div 4 high count");
    count_high(8'd5, 16, "R10 div 5 high count");
    count_high(8'd1, 0, "R10 div 1 held low");
    count_high(8'd0, 0, "R10 div 0 held low");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule